// File: doc/BRIEF.md
# Down-Counting Pulse Timer with Reload

This block is a down-counter of configurable width (24 bits by default) that drives a toggling flip-flop output. It advances only on a count strobe, a one-cycle pulse on the bus clock that an external prescaler supplies. Software writes the counter preset, the reload value, the mode, the flip-flop level and the enable bit through simple write strobes. It reads the live count and the enable state back from the output ports.

In single-shot mode, the start loads the counter from the reload register. The counter then runs down to zero, underflows once and stops, clearing its own enable. The output therefore carries exactly one pulse, reload + 1 count periods wide. In continuous mode, counting starts from the value written into the counter. Every underflow reloads the counter from the reload register, so the output is a pulse train whose half-period is reload + 1 count periods. The train runs until software clears the enable.

Each underflow raises a one-cycle interrupt request and a one-cycle DMA request together. A newly written enable does nothing until the next count strobe. That strobe performs the start action, which loads the counter (single-shot only) and inverts the output.

Top module: `ocPulseTimer`

## Requirements
- R1: While running, every count strobe on which the counter is nonzero lowers the counter by exactly one.
- R2: Setting the enable (enWr with enWrData=1 while disabled) changes neither the output nor the counter until the next count strobe. That strobe is the start: it inverts toggleOut and does not count.
- R3: Single-shot mode (modeCont=0): the start loads the counter from the reload register. The strobe that finds the counter at 0 is the underflow. It leaves the counter at 0, clears enabled and inverts toggleOut, so the pulse spans reload+1 strobes. After that, no further strobe has any effect.
- R4: Continuous mode (modeCont=1): the start keeps the counter's written value. Every strobe that finds the counter at 0 loads the reload value instead of wrapping, and counting goes on.
- R5: toggleOut inverts exactly at the start and at every underflow, and at no other strobe.
- R6: Each underflow makes irqReq and dmaReq high together for exactly the one bus-clock cycle that follows the underflow edge.
- R7: A counter write (cntWr) is stored and shown on cntValue only while disabled. While enabled it is ignored.
- R8: A disabling write (enWr with enWrData=0) freezes the counter and output from that same edge, even when a strobe coincides with it. No request is raised while disabled.
- R9: ffSet loads ffSetVal into toggleOut while disabled and is ignored while enabled. Reset leaves toggleOut, cntValue, enabled and both requests at 0.
- R10: The reload register can be written at any time, and an underflow uses the value held at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntTick | input | 1 | Count strobe, one bus-clock cycle wide |
| cntWr | input | 1 | Write wrData into the counter (disabled only) |
| reloadWr | input | 1 | Write wrData into the reload register |
| wrData | input | CNT_W | Write data for counter or reload |
| modeCont | input | 1 | 1 = continuous, 0 = single-shot |
| enWr | input | 1 | Write enWrData into the enable bit |
| enWrData | input | 1 | Enable bit value |
| ffSet | input | 1 | Load ffSetVal into the output flip-flop (disabled only) |
| ffSetVal | input | 1 | Flip-flop preset level |
| cntValue | output | CNT_W | Live counter value |
| enabled | output | 1 | Enable bit, cleared by single-shot completion |
| toggleOut | output | 1 | Flip-flop pulse output |
| irqReq | output | 1 | Interrupt request, one cycle per underflow |
| dmaReq | output | 1 | DMA request, one cycle per underflow |

## Verification
The bench builds the block at its default width of 24 bits. Because the counter and reload register are loaded directly, values such as 0xFFFFFF and 0xFFFFFE can be reached in a handful of strobes. Those values check that a full-scale reload and the decrement below it behave without a wrap. The vector table covers zero and full-scale reloads in both modes, including back-to-back underflows with reload 0. Directed cases cover a strobe that coincides with a disabling write and a reload rewritten just before an underflow.

// File: rtl/ocTimerPkg.sv
package ocTimerPkg;
  typedef struct packed {
    logic loadReload;
    logic loadWrite;
    logic decrement;
    logic toggle;
    logic ffLoad;
  } dpCtl_t;
endpackage

// File: rtl/ocTimerCtrl.sv
module ocTimerCtrl
  import ocTimerPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   cntTick,
  input  logic   cntWr,
  input  logic   modeCont,
  input  logic   enWr,
  input  logic   enWrData,
  input  logic   ffSet,
  input  logic   cntZero,
  output dpCtl_t ctl,
  output logic   enabled,
  output logic   startPend,
  output logic   irqReq,
  output logic   dmaReq
);
  logic enBit, pendQ;
  logic disableNow, enableNow, runTick, startTick, underflow;

  assign disableNow = enWr && !enWrData;
  assign enableNow  = enWr && enWrData && !enBit;
  assign startTick  = pendQ && cntTick && !disableNow;
  assign runTick    = enBit && !pendQ && cntTick && !disableNow;
  assign underflow  = runTick && cntZero;

  always_comb begin
    ctl.loadReload = (startTick && !modeCont) || (underflow && modeCont);
    ctl.decrement  = runTick && !cntZero;
    ctl.loadWrite  = cntWr && !enBit;
    ctl.toggle     = startTick || underflow;
    ctl.ffLoad     = ffSet && !enBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit  <= 1'b0;
      pendQ  <= 1'b0;
      irqReq <= 1'b0;
      dmaReq <= 1'b0;
    end else begin
      irqReq <= underflow;
      dmaReq <= underflow;
      if (disableNow) begin
        enBit <= 1'b0;
        pendQ <= 1'b0;
      end else if (enableNow) begin
        enBit <= 1'b1;
        pendQ <= 1'b1;
      end else begin
        if (startTick) pendQ <= 1'b0;
        if (underflow && !modeCont) enBit <= 1'b0;
      end
    end
  end

  assign enabled   = enBit;
  assign startPend = pendQ;
endmodule

// File: rtl/ocTimerDatapath.sv
module ocTimerDatapath
  import ocTimerPkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic             reloadWr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             ffSetVal,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] reloadQ,
  output logic             cntZero,
  output logic             ffQ
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      reloadQ <= '0;
      ffQ     <= 1'b0;
    end else begin
      if (reloadWr) reloadQ <= wrData;
      if (ctl.loadReload)     cntQ <= reloadQ;
      else if (ctl.decrement) cntQ <= cntQ - ONE;
      else if (ctl.loadWrite) cntQ <= wrData;
      if (ctl.toggle)      ffQ <= ~ffQ;
      else if (ctl.ffLoad) ffQ <= ffSetVal;
    end
  end

  assign cntZero = (cntQ == '0);
endmodule

// File: rtl/ocPulseTimer.sv
module ocPulseTimer
  import ocTimerPkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntTick,
  input  logic             cntWr,
  input  logic             reloadWr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             modeCont,
  input  logic             enWr,
  input  logic             enWrData,
  input  logic             ffSet,
  input  logic             ffSetVal,
  output logic [CNT_W-1:0] cntValue,
  output logic             enabled,
  output logic             toggleOut,
  output logic             irqReq,
  output logic             dmaReq
);
  dpCtl_t           ctl;
  logic             cntZero;
  logic             startPend;
  logic [CNT_W-1:0] reloadQ;

  ocTimerCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .cntWr(cntWr),
    .modeCont(modeCont), .enWr(enWr), .enWrData(enWrData), .ffSet(ffSet),
    .cntZero(cntZero), .ctl(ctl), .enabled(enabled), .startPend(startPend),
    .irqReq(irqReq), .dmaReq(dmaReq)
  );

  ocTimerDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reloadWr(reloadWr), .wrData(wrData),
    .ffSetVal(ffSetVal), .cntQ(cntValue), .reloadQ(reloadQ),
    .cntZero(cntZero), .ffQ(toggleOut)
  );
endmodule

// File: rtl/ocPulseTimerChk.sv
module ocPulseTimerChk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             cntTick,
  input logic             cntWr,
  input logic             modeCont,
  input logic             enWr,
  input logic             enWrData,
  input logic [CNT_W-1:0] cntValue,
  input logic [CNT_W-1:0] reloadQ,
  input logic             startPend,
  input logic             enabled,
  input logic             toggleOut,
  input logic             irqReq,
  input logic             dmaReq
);
  logic liveTick;
  assign liveTick = enabled && !startPend && cntTick && !(enWr && !enWrData);

  p_count_down_r1: assert property (@(posedge clk) disable iff (!rstN)
    (liveTick && cntValue != '0) |=> cntValue == $past(cntValue) - CNT_W'(1));

  p_start_wait_r2: assert property (@(posedge clk) disable iff (!rstN)
    (startPend && !cntTick) |=> ($stable(toggleOut) && $stable(cntValue)));

  p_single_stop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !$past(modeCont) && !$past(enWr)) |-> (!enabled && cntValue == '0));

  p_cont_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
    (liveTick && cntValue == '0 && modeCont) |=> cntValue == $past(reloadQ));

  p_req_toggle_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> toggleOut != $past(toggleOut));

  p_no_req_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |=> (!irqReq && !dmaReq));

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!enabled && !cntWr) |=> $stable(cntValue));
endmodule

bind ocPulseTimer ocPulseTimerChk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cntTick(cntTick), .cntWr(cntWr),
  .modeCont(modeCont), .enWr(enWr), .enWrData(enWrData),
  .cntValue(cntValue), .reloadQ(reloadQ), .startPend(startPend),
  .enabled(enabled), .toggleOut(toggleOut), .irqReq(irqReq), .dmaReq(dmaReq)
);

// File: tb/sim_ocPulseTimer.sv
`timescale 1ns/1ps
module sim_ocPulseTimer;
  localparam int W = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cntTick = 0, cntWr = 0, reloadWr = 0, modeCont = 0;
  logic enWr = 0, enWrData = 0, ffSet = 0, ffSetVal = 0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] cntValue;
  logic enabled, toggleOut, irqReq, dmaReq;

  int nChecks = 0, nFails = 0;
  int irqCnt = 0, togCnt = 0, pairErr = 0;
  logic lastTog = 1'b0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  ocPulseTimer #(.CNT_W(W)) u0 (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .cntWr(cntWr),
    .reloadWr(reloadWr), .wrData(wrData), .modeCont(modeCont),
    .enWr(enWr), .enWrData(enWrData), .ffSet(ffSet), .ffSetVal(ffSetVal),
    .cntValue(cntValue), .enabled(enabled), .toggleOut(toggleOut),
    .irqReq(irqReq), .dmaReq(dmaReq)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (irqReq !== dmaReq) pairErr++;
      if (irqReq) irqCnt++;
      if (toggleOut !== lastTog) togCnt++;
    end
    lastTog = toggleOut;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tickOnce();
    @(negedge clk) cntTick = 1;
    @(negedge clk) cntTick = 0;
    @(negedge clk);
  endtask
  task automatic writeCnt(input logic [W-1:0] v);
    @(negedge clk) begin cntWr = 1; wrData = v; end
    @(negedge clk) cntWr = 0;
  endtask
  task automatic writeReload(input logic [W-1:0] v);
    @(negedge clk) begin reloadWr = 1; wrData = v; end
    @(negedge clk) reloadWr = 0;
  endtask
  task automatic setEnable(input logic b);
    @(negedge clk) begin enWr = 1; enWrData = b; end
    @(negedge clk) enWr = 0;
  endtask
  task automatic ffLoad(input logic b);
    @(negedge clk) begin ffSet = 1; ffSetVal = b; end
    @(negedge clk) ffSet = 0;
  endtask

  typedef struct packed {
    logic         mode;
    logic [W-1:0] preset;
    logic [W-1:0] reload;
    logic [7:0]   ticks;
    logic [7:0]   expIrq;
    logic [W-1:0] expCnt;
    logic         expEn;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 24'h000123, 24'h000005, 8'd4,  8'd0, 24'h000002, 1'b1},
    '{1'b0, 24'h000123, 24'h000005, 8'd7,  8'd1, 24'h000000, 1'b0},
    '{1'b0, 24'h000123, 24'h000005, 8'd10, 8'd1, 24'h000000, 1'b0},
    '{1'b0, 24'h000077, 24'h000000, 8'd2,  8'd1, 24'h000000, 1'b0},
    '{1'b1, 24'h000003, 24'h000002, 8'd4,  8'd0, 24'h000000, 1'b1},
    '{1'b1, 24'h000003, 24'h000002, 8'd5,  8'd1, 24'h000002, 1'b1},
    '{1'b1, 24'h000003, 24'h000002, 8'd12, 8'd3, 24'h000001, 1'b1},
    '{1'b1, 24'h000000, 24'h000000, 8'd6,  8'd5, 24'h000000, 1'b1},
    '{1'b1, 24'h000001, 24'hFFFFFF, 8'd4,  8'd1, 24'hFFFFFE, 1'b1},
    '{1'b0, 24'h000009, 24'hFFFFFF, 8'd3,  8'd0, 24'hFFFFFD, 1'b1}
  };

  initial begin
    int i0, t0, p0;
    repeat (3) @(negedge clk);
    check("reset R9 toggleOut", {31'd0, toggleOut}, 32'd0);
    check("reset R9 enabled", {31'd0, enabled}, 32'd0);
    check("reset R9 cntValue", {8'd0, cntValue}, 32'd0);
    check("reset R6 irqReq", {31'd0, irqReq}, 32'd0);
    @(negedge clk) rstN = 1;
    @(negedge clk);

    // Vector table: R1 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      setEnable(0);
      ffLoad(0);
      @(negedge clk) modeCont = VECS[v].mode;
      writeCnt(VECS[v].preset);
      writeReload(VECS[v].reload);
      i0 = irqCnt; t0 = togCnt; p0 = pairErr;
      setEnable(1);
      for (int k = 0; k < int'(VECS[v].ticks); k++) tickOnce();
      repeat (2) @(negedge clk);
      check(VECS[v].mode ? "vec R4 R1 cntValue" : "vec R3 R1 cntValue",
            {8'd0, cntValue}, {8'd0, VECS[v].expCnt});
      check("vec R3 enabled", {31'd0, enabled}, {31'd0, VECS[v].expEn});
      check("vec R6 irq pulses", irqCnt - i0, {24'd0, VECS[v].expIrq});
      check("vec R5 toggles", togCnt - t0, 32'd1 + {24'd0, VECS[v].expIrq});
      check("vec R6 irq/dma pairing", pairErr - p0, 32'd0);
    end

    // R2: enable waits for strobe
    setEnable(0);
    ffLoad(0);
    @(negedge clk) modeCont = 0;
    writeCnt(24'd7);
    writeReload(24'd4);
    setEnable(1);
    repeat (5) @(negedge clk);
    check("R2 output held before strobe", {31'd0, toggleOut}, 32'd0);
    check("R2 counter held before strobe", {8'd0, cntValue}, 32'd7);
    check("R2 enabled set", {31'd0, enabled}, 32'd1);
    tickOnce();
    check("R2 start inverts output", {31'd0, toggleOut}, 32'd1);
    check("R3 start loads reload", {8'd0, cntValue}, 32'd4);

    // R7: counter write ignored while enabled
    writeCnt(24'h55);
    check("R7 write ignored while enabled", {8'd0, cntValue}, 32'd4);
    tickOnce();
    check("R1 count after ignored write", {8'd0, cntValue}, 32'd3);

    // R8: strobe coinciding with disabling write
    i0 = irqCnt;
    @(negedge clk) begin enWr = 1; enWrData = 0; cntTick = 1; end
    @(negedge clk) begin enWr = 0; cntTick = 0; end
    @(negedge clk);
    check("R8 counter frozen at disable", {8'd0, cntValue}, 32'd3);
    check("R8 enabled cleared", {31'd0, enabled}, 32'd0);
    check("R8 output frozen", {31'd0, toggleOut}, 32'd1);
    tickOnce();
    check("R8 strobe while disabled", {8'd0, cntValue}, 32'd3);
    check("R8 no request", irqCnt - i0, 32'd0);

    // R9: flip-flop preset
    ffLoad(0);
    check("R9 preset low", {31'd0, toggleOut}, 32'd0);
    ffLoad(1);
    check("R9 preset high", {31'd0, toggleOut}, 32'd1);
    @(negedge clk) modeCont = 1;
    writeCnt(24'd2);
    writeReload(24'd1);
    setEnable(1);
    ffLoad(0);
    check("R9 preset ignored while enabled", {31'd0, toggleOut}, 32'd1);

    // R10 / R4: reload rewritten before underflow
    tickOnce();
    check("R4 start keeps preset", {8'd0, cntValue}, 32'd2);
    check("R5 start toggles", {31'd0, toggleOut}, 32'd0);
    tickOnce();
    tickOnce();
    check("R1 reaches zero", {8'd0, cntValue}, 32'd0);
    writeReload(24'd6);
    i0 = irqCnt;
    tickOnce();
    check("R10 new reload used", {8'd0, cntValue}, 32'd6);
    check("R5 underflow toggles", {31'd0, toggleOut}, 32'd1);
    check("R6 one request", irqCnt - i0, 32'd1);

    // R7: write stored while disabled, used by continuous start
    setEnable(0);
    writeCnt(24'hABCDEF);
    check("R7 write stored while disabled", {8'd0, cntValue}, 32'h00ABCDEF);
    setEnable(1);
    tickOnce();
    check("R4 start from written value", {8'd0, cntValue}, 32'h00ABCDEF);
    tickOnce();
    check("R1 decrement", {8'd0, cntValue}, 32'h00ABCDEE);
    check("R6 pairing overall", pairErr, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule